// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frame data from a receive FIFO into host memory buffers described by a ring of descriptors. Each descriptor occupies four consecutive 32-bit words: a status word, a buffer size word, a buffer pointer word and a spare word. The last two words double as the timestamp slots of the descriptor that closes a frame. The engine reaches memory through a single request/acknowledge port, one access at a time.

Once started, the engine always reads the next descriptor before a frame needs it, so a spare buffer is ready when the first word arrives. A frame that overflows its buffer is split across as many descriptors as it needs, with first and last segment flags set on the right ones. If the engine reads a descriptor still owned by the host, it raises a buffer-unavailable flag and suspends at that ring position. It leaves suspension on a poll demand, or when a new frame appears while it is between frames. A stop request is honoured only between frames.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset `proc_state` is 2'b00 (stopped), `mem_req`, `fifo_ready`, `rx_int` and `buf_unavail` are 0, and `proc_state` never takes the value 2'b11.
- R2: When `run` is raised in the stopped state, the engine reads words 0, 1 and 2 of the current descriptor, at `ring_base + 16*index`. If bit 31 of word 0 is 1, it then waits for a frame, with `proc_state` at 2'b01 and no further memory access.
- R3: Frame words are written in arrival order to `buffer_pointer + 4*k`. A FIFO word is popped (`fifo_ready` high) only in the cycle its memory write is acknowledged.
- R4: A frame that fits one buffer closes that descriptor with a word-0 write. That write has bit 31 = 0, bit 9 = 1, bit 8 = 1 and the segment's word count in bits 27:16. It is the last write to that descriptor and follows all of its buffer writes.
- R5: A frame longer than the buffer size (word 1, bits 11:0, in words) closes each full buffer and continues in the next descriptor. Bit 9 is set only on the first segment, bit 8 only on the last, and bits 27:16 hold each segment's own word count.
- R6: After a frame's last segment is closed, the engine reads the next descriptor's word 0. `rx_int` becomes 1 in the cycle after that read is acknowledged.
- R7: A descriptor read with word-0 bit 31 = 0 sets `buf_unavail`, moves `proc_state` to 2'b10 and keeps the ring index. A `poll` pulse, or a rise of `fifo_valid` while suspended between frames, re-reads the same descriptor.
- R8: With `stamp_en` = 1 at frame end, words 2 and 3 of the closing descriptor are written before its word 0. They receive `fifo_ts[31:0]` and `fifo_ts[63:32]` if `fifo_ts_ok` was set with the last word, and all ones otherwise. With `stamp_en` = 0, words 2 and 3 are not written.
- R9: After the descriptor at index `ring_last`, the next descriptor is at index 0 (`ring_base`).
- R10: Lowering `run` takes effect only between frames: a frame in progress completes and the spare descriptor is fetched before `proc_state` becomes 2'b00. A later `run` re-reads the same spare descriptor.
- R11: Once raised, `mem_req` stays high with stable `mem_we`, `mem_addr` and `mem_wdata` until `mem_ack`.
- R12: `rx_int` and `buf_unavail` stay set until their clear input is pulsed; a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start (1) or stop (0) request |
| poll | input | 1 | Poll demand pulse |
| stamp_en | input | 1 | Timestamp write-back enable |
| ring_base | input | AW | Byte address of descriptor 0 |
| ring_last | input | IW | Index of the last descriptor in the ring |
| clr_rx_int | input | 1 | Clears `rx_int` |
| clr_buf_unavail | input | 1 | Clears `buf_unavail` |
| fifo_valid | input | 1 | FIFO word available |
| fifo_data | input | 32 | FIFO word |
| fifo_last | input | 1 | Word is the last of its frame |
| fifo_ts_ok | input | 1 | Timestamp valid, qualified by `fifo_last` |
| fifo_ts | input | 64 | Frame timestamp, qualified by `fifo_last` |
| fifo_ready | output | 1 | FIFO word consumed |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| rx_int | output | 1 | Sticky frame-received flag |
| buf_unavail | output | 1 | Sticky host-owned-descriptor flag |
| proc_state | output | 2 | 00 stopped, 01 running, 10 suspended |

## Verification
A wrong ring index or stale buffer pointer shows at the memory port on the very next access, as a wrong address. A wrong segment counter shows when the buffer fills, as a misplaced status write or a wrong word count in bits 27:16. A lost first/last flag or suspension state only shows when the descriptor closes or the next one is fetched, so every frame is followed by a check of each status word and each buffer word. Random frame lengths, buffer sizes, timestamp modes and memory latencies push segment boundaries into every position.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int AW = 32,
  parameter int BW = 12,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          poll,
  input  logic          stamp_en,
  input  logic [AW-1:0] ring_base,
  input  logic [IW-1:0] ring_last,
  input  logic          clr_rx_int,
  input  logic          clr_buf_unavail,
  input  logic          fifo_valid,
  input  logic [31:0]   fifo_data,
  input  logic          fifo_last,
  input  logic          fifo_ts_ok,
  input  logic [63:0]   fifo_ts,
  output logic          fifo_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          rx_int,
  output logic          buf_unavail,
  output logic [1:0]    proc_state
);

  typedef enum logic [3:0] {
    S_STOP, S_RD0, S_RD1, S_RD2, S_IDLE, S_DATA, S_TS0, S_TS1, S_WST, S_SUSP
  } st_t;

  st_t           st;
  logic [IW-1:0] idx;
  logic [BW-1:0] cap, cnt;
  logic [AW-1:0] bptr;
  logic          first_q, last_q, mid_q, irq_pend, vld_q, ok_q;
  logic [63:0]   ts_q;
  logic [31:0]   stat_w;

  wire [AW-1:0] dbase = ring_base + AW'({idx, 4'b0000});
  wire          full  = (cnt == cap);

  always_comb begin
    stat_w            = '0;
    stat_w[16 +: BW]  = cnt;
    stat_w[9]         = first_q;
    stat_w[8]         = last_q;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = dbase;
    mem_wdata = '0;
    case (st)
      S_RD0: mem_req = 1'b1;
      S_RD1: begin mem_req = 1'b1; mem_addr = dbase + AW'(4); end
      S_RD2: begin mem_req = 1'b1; mem_addr = dbase + AW'(8); end
      S_DATA: begin
        mem_req   = fifo_valid && !full;
        mem_we    = 1'b1;
        mem_addr  = bptr + AW'({cnt, 2'b00});
        mem_wdata = fifo_data;
      end
      S_TS0: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = dbase + AW'(8);
        mem_wdata = ok_q ? ts_q[31:0] : '1;
      end
      S_TS1: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = dbase + AW'(12);
        mem_wdata = ok_q ? ts_q[63:32] : '1;
      end
      S_WST: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = stat_w; end
      default: ;
    endcase
  end

  assign fifo_ready = (st == S_DATA) && mem_ack && !full;
  assign proc_state = (st == S_STOP) ? 2'b00 : (st == S_SUSP) ? 2'b10 : 2'b01;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_STOP;
      idx         <= '0;
      cap         <= '0;
      cnt         <= '0;
      bptr        <= '0;
      first_q     <= 1'b0;
      last_q      <= 1'b0;
      mid_q       <= 1'b0;
      irq_pend    <= 1'b0;
      vld_q       <= 1'b0;
      ok_q        <= 1'b0;
      ts_q        <= '0;
      rx_int      <= 1'b0;
      buf_unavail <= 1'b0;
    end else begin
      vld_q <= fifo_valid;
      if (clr_rx_int)      rx_int      <= 1'b0;
      if (clr_buf_unavail) buf_unavail <= 1'b0;
      case (st)
        S_STOP: if (run) st <= S_RD0;
        S_RD0: if (mem_ack) begin
          if (irq_pend) begin
            rx_int   <= 1'b1;
            irq_pend <= 1'b0;
          end
          if (mem_rdata[31]) st <= S_RD1;
          else begin
            buf_unavail <= 1'b1;
            st          <= S_SUSP;
          end
        end
        S_RD1: if (mem_ack) begin
          cap <= mem_rdata[BW-1:0];
          st  <= S_RD2;
        end
        S_RD2: if (mem_ack) begin
          bptr <= AW'(mem_rdata);
          cnt  <= '0;
          st   <= mid_q ? S_DATA : S_IDLE;
        end
        S_IDLE: begin
          if (!run) st <= S_STOP;
          else if (fifo_valid) begin
            first_q <= 1'b1;
            st      <= S_DATA;
          end
        end
        S_DATA: begin
          if (full) begin
            last_q <= 1'b0;
            st     <= S_WST;
          end else if (mem_ack) begin
            cnt <= cnt + 1'b1;
            if (fifo_last) begin
              last_q <= 1'b1;
              ok_q   <= fifo_ts_ok;
              ts_q   <= fifo_ts;
              st     <= stamp_en ? S_TS0 : S_WST;
            end
          end
        end
        S_TS0: if (mem_ack) st <= S_TS1;
        S_TS1: if (mem_ack) st <= S_WST;
        S_WST: if (mem_ack) begin
          idx      <= (idx == ring_last) ? '0 : idx + 1'b1;
          first_q  <= 1'b0;
          mid_q    <= !last_q;
          irq_pend <= last_q;
          st       <= S_RD0;
        end
        S_SUSP: begin
          if (poll || (!mid_q && fifo_valid && !vld_q)) st <= S_RD0;
          else if (!mid_q && !run) st <= S_STOP;
        end
        default: st <= S_STOP;
      endcase
    end
  end

endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          fifo_valid,
  input logic          fifo_ready,
  input logic          rx_int,
  input logic          buf_unavail,
  input logic [1:0]    proc_state
);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_pop_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> fifo_valid && mem_req && mem_we && mem_ack);

  p_irq_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_int) |-> $past(mem_req && mem_ack && !mem_we));

  p_unavail_suspends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_unavail) |-> proc_state == 2'b10);

  p_stop_on_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 2'b00 && $past(proc_state) != 2'b00) |-> !$past(run));

  p_quiet_when_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    proc_state == 2'b00 |-> !mem_req);

  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    proc_state != 2'b11);

endmodule

bind rx_ring_dma rx_ring_dma_chk #(.AW(AW)) u_chk (.*);

// File: tb/rx_ring_dma_bench.sv
`timescale 1ns/1ps
module rx_ring_dma_bench;
  localparam int AW = 32;
  localparam int BW = 12;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          run = 0, poll = 0, stamp_en = 0, clr_rx_int = 0, clr_buf_unavail = 0;
  logic [AW-1:0] ring_base = 32'h100;
  logic [IW-1:0] ring_last = 4'd3;
  logic          fifo_valid, fifo_last, fifo_ts_ok, fifo_ready;
  logic [31:0]   fifo_data;
  logic [63:0]   fifo_ts;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          rx_int, buf_unavail;
  logic [1:0]    proc_state;

  rx_ring_dma #(.AW(AW), .BW(BW), .IW(IW)) u_rx_ring_dma (
    .clk(clk), .rst_n(rst_n), .run(run), .poll(poll), .stamp_en(stamp_en),
    .ring_base(ring_base), .ring_last(ring_last), .clr_rx_int(clr_rx_int),
    .clr_buf_unavail(clr_buf_unavail), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_last(fifo_last), .fifo_ts_ok(fifo_ts_ok), .fifo_ts(fifo_ts),
    .fifo_ready(fifo_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rx_int(rx_int),
    .buf_unavail(buf_unavail), .proc_state(proc_state));

  // memory model, host writes and access log
  logic [31:0] mem [0:1023];
  logic [31:0] lg_addr [0:2047];
  logic        lg_we   [0:2047];
  int          nlg = 0;
  int          dly = 0;
  int          maxlat = 0;
  logic        h_we = 0;
  logic [31:0] h_addr = 0, h_data = 0;

  always @(posedge clk) begin
    if (h_we) mem[h_addr[11:2]] <= h_data;
    if (!rst_n) begin
      mem_ack <= 1'b0;
      dly     <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (dly == 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[11:2]];
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        lg_addr[nlg] <= mem_addr;
        lg_we[nlg]   <= mem_we;
        nlg          <= nlg + 1;
        dly          <= $urandom_range(maxlat, 0);
      end else dly <= dly - 1;
    end
  end

  // receive FIFO model
  logic [31:0] q_data [0:511];
  logic        q_last [0:511];
  logic        q_ok   [0:511];
  logic [63:0] q_ts   [0:511];
  int head = 0, tail = 0;
  always @(posedge clk) if (fifo_ready) head <= head + 1;
  assign fifo_valid = (head != tail);
  assign fifo_data  = q_data[head[8:0]];
  assign fifo_last  = q_last[head[8:0]];
  assign fifo_ts_ok = q_ok[head[8:0]];
  assign fifo_ts    = q_ts[head[8:0]];

  int errs = 0, checks = 0;
  int m_idx = 0;
  int sz [0:3];
  logic [31:0] fr [0:15];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] dsc(int m); return 32'h100 + 32'(m) * 32'd16; endfunction
  function automatic logic [31:0] bpa(int m); return 32'h400 + 32'(m) * 32'h80; endfunction
  function automatic logic [31:0] expst(int n, bit f, bit l);
    return (32'(n) << 16) | (32'(f) << 9) | (32'(l) << 8);
  endfunction

  task automatic hwr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); h_addr = a; h_data = d; h_we = 1'b1;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic init_desc(int m, int s);
    sz[m] = s;
    hwr(dsc(m) + 4, 32'(s));
    hwr(dsc(m) + 8, bpa(m));
    hwr(dsc(m) + 12, 32'h0);
    hwr(dsc(m), 32'h8000_0000);
  endtask

  task automatic restore_released();
    for (int m = 0; m < 4; m++)
      if (mem[dsc(m) >> 2][31] == 1'b0) init_desc(m, $urandom_range(5, 2));
  endtask

  task automatic send(int len, bit ok, logic [63:0] ts);
    @(negedge clk);
    for (int k = 0; k < len; k++) begin
      fr[k] = $urandom;
      q_data[(tail + k) % 512] = fr[k];
      q_last[(tail + k) % 512] = (k == len - 1);
      q_ok[(tail + k) % 512]   = ok;
      q_ts[(tail + k) % 512]   = ts;
    end
    tail = tail + len;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 10) begin
      @(negedge clk);
      if (!mem_req && !fifo_valid) q++; else q = 0;
    end
  endtask

  task automatic pulse_clear(bit irq, bit bu);
    @(negedge clk); clr_rx_int = irq; clr_buf_unavail = bu;
    @(negedge clk); clr_rx_int = 0; clr_buf_unavail = 0;
  endtask

  task automatic check_frame(int len, bit en, bit ok, logic [63:0] ts);
    int rem = len, k = 0;
    bit f = 1;
    string tag = (len > sz[m_idx]) ? "R5" : "R4";
    while (rem > 0) begin
      int n = (rem < sz[m_idx]) ? rem : sz[m_idx];
      bit l = (n == rem);
      for (int j = 0; j < n; j++)
        chk("R3", "buffer word", mem[(bpa(m_idx) >> 2) + j], fr[k + j]);
      chk(tag, "status word", mem[dsc(m_idx) >> 2], expst(n, f, l));
      if (l && en) begin
        chk("R8", "stamp low", mem[(dsc(m_idx) >> 2) + 2], ok ? ts[31:0] : 32'hffff_ffff);
        chk("R8", "stamp high", mem[(dsc(m_idx) >> 2) + 3], ok ? ts[63:32] : 32'hffff_ffff);
      end else begin
        chk("R8", "word2 untouched", mem[(dsc(m_idx) >> 2) + 2], bpa(m_idx));
        chk("R8", "word3 untouched", mem[(dsc(m_idx) >> 2) + 3], 32'h0);
      end
      rem -= n; k += n; f = 0;
      m_idx = (m_idx + 1) % 4;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base, len;
    bit en, ok;
    logic [63:0] ts;
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "proc_state", 32'(proc_state), 32'h0);
    chk("R1", "mem_req", 32'(mem_req), 32'h0);
    chk("R1", "fifo_ready", 32'(fifo_ready), 32'h0);
    chk("R1", "rx_int", 32'(rx_int), 32'h0);
    chk("R1", "buf_unavail", 32'(buf_unavail), 32'h0);
    rst_n = 1'b1;
    init_desc(0, 8); init_desc(1, 4); init_desc(2, 4); init_desc(3, 8);

    // R2 start fetches the spare descriptor
    run = 1'b1;
    wait_quiet();
    chk("R2", "accesses after start", 32'(nlg), 32'd3);
    chk("R2", "read w0", lg_addr[0], 32'h100);
    chk("R2", "read w1", lg_addr[1], 32'h104);
    chk("R2", "read w2", lg_addr[2], 32'h108);
    chk("R2", "reads only", 32'(lg_we[0] | lg_we[1] | lg_we[2]), 32'h0);
    chk("R2", "running", 32'(proc_state), 32'h1);

    // single-descriptor frame, ordering of writes
    base = nlg;
    send(5, 0, 64'h0);
    wait_quiet();
    for (int k = 0; k < 5; k++) chk("R3", "write order", lg_addr[base + k], 32'h400 + 32'(k) * 4);
    chk("R4", "status written after data", lg_addr[base + 5], 32'h100);
    chk("R4", "status is a write", 32'(lg_we[base + 5]), 32'h1);
    chk("R6", "next fetch follows close", lg_addr[base + 6], 32'h110);
    chk("R6", "rx_int set", 32'(rx_int), 32'h1);
    check_frame(5, 0, 0, 64'h0);
    pulse_clear(1, 0);
    chk("R12", "rx_int cleared", 32'(rx_int), 32'h0);

    // two-segment frame with valid timestamp
    stamp_en = 1'b1;
    send(7, 1, 64'h0123_4567_89ab_cdef);
    wait_quiet();
    check_frame(7, 1, 1, 64'h0123_4567_89ab_cdef);

    // invalid timestamp, then wrap onto a released descriptor
    send(3, 0, 64'h5555_aaaa_5555_aaaa);
    wait_quiet();
    check_frame(3, 1, 0, 64'h0);
    chk("R9", "wrap to ring base", lg_addr[nlg - 1], 32'h100);
    chk("R7", "buf_unavail set", 32'(buf_unavail), 32'h1);
    chk("R7", "suspended", 32'(proc_state), 32'h2);
    stamp_en = 1'b0;

    // poll resumes at the same position
    init_desc(0, 8);
    @(negedge clk); poll = 1'b1; @(negedge clk); poll = 1'b0;
    wait_quiet();
    chk("R7", "running after poll", 32'(proc_state), 32'h1);
    chk("R7", "refetch w0", lg_addr[nlg - 3], 32'h100);
    chk("R12", "buf_unavail sticky", 32'(buf_unavail), 32'h1);
    pulse_clear(0, 1);
    chk("R12", "buf_unavail cleared", 32'(buf_unavail), 32'h0);

    // suspend, then a new frame triggers the refetch
    send(2, 0, 64'h0);
    wait_quiet();
    check_frame(2, 0, 0, 64'h0);
    chk("R7", "suspended on released", 32'(proc_state), 32'h2);
    init_desc(1, 4); init_desc(2, 4); init_desc(3, 8); init_desc(0, 8);
    send(3, 0, 64'h0);
    wait_quiet();
    chk("R7", "new frame resumes", 32'(proc_state), 32'h1);
    check_frame(3, 0, 0, 64'h0);

    // stop request during a frame
    send(6, 0, 64'h0);
    while (!fifo_ready) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk("R10", "still running mid-frame", 32'(proc_state), 32'h1);
    wait_quiet();
    check_frame(6, 0, 0, 64'h0);
    chk("R10", "stopped at boundary", 32'(proc_state), 32'h0);
    base = nlg;
    run = 1'b1;
    wait_quiet();
    chk("R10", "restart re-reads spare", lg_addr[base], dsc(m_idx));
    chk("R10", "running again", 32'(proc_state), 32'h1);
    pulse_clear(1, 1);

    // random frames
    for (int it = 0; it < 24; it++) begin
      restore_released();
      maxlat = $urandom_range(3, 0);
      len = $urandom_range(6, 1);
      en = 1'($urandom_range(1, 0));
      ok = 1'($urandom_range(1, 0));
      ts = {$urandom, $urandom};
      stamp_en = en;
      send(len, ok, ts);
      wait_quiet();
      check_frame(len, en, ok, ts);
      chk("R6", "rx_int after frame", 32'(rx_int), 32'h1);
      chk("R2", "holding spare", 32'(proc_state), 32'h1);
      pulse_clear(1, 0);
    end
    finish_run();
  end
endmodule